// File: doc/BRIEF.md
# Periodic-Correction Calibration Divider

This block turns a stream of oscillator enables, 32,768 of them per nominal second, into a one-second tick. It also gives a marker on the tick that closes each minute, and a 512 Hz square wave for measuring the crystal. The divider is built from a divide-by-256 stage followed by a divide-by-128 stage. A free-running counter of its own makes the square wave, ahead of any correction, so that calibration never moves its frequency.

Rate correction works in whole seconds. The block keeps a 64-minute cycle. For a calibration value N, the first second of each of the first 2N minutes is trimmed. With the sign set, the trimmed second is shortened by 256 enables: one extra count is injected into the divide-by-256 stage on each of that second's first 256 enables. With the sign clear, it is lengthened by 128 enables: the count is suppressed on that second's first 128 enables. Minutes 62 and 63 are never trimmed.

A divider reset clears every counter, including the second-in-minute, the minute-in-cycle and the wave counter. It is meant to be pulsed after the time is written. While the stop input is high, nothing advances and no tick is emitted.

Top module: `calClockDivider`

## Requirements
- R1: While rstN is low, secTick, minuteMark and testWave are all 0.
- R2: With calMag = 0, every second lasts exactly 2^(STAGE_A_W+STAGE_B_W) counted enables, that is 32,768 with the defaults. A counted enable is a cycle with oscEn = 1, stopBit = 0 and no divider reset.
- R3: With calSign = 1 (speed up) and calMag = N, second 0 of each minute m < 2N in the 64-minute cycle is 2^STAGE_A_W enables shorter than nominal, that is 256 with the defaults.
- R4: With calSign = 0 (slow down) and calMag = N, second 0 of each minute m < 2N is 2^(STAGE_A_W-1) enables longer than nominal, that is 128 with the defaults.
- R5: Every second other than second 0 of the minutes m < 2N is nominal. Minutes 62 and 63 are never adjusted. The minute count wraps after 64 minutes and the pattern repeats.
- R6: minuteMark pulses together with the secTick that ends second SEC_PER_MIN-1 of a minute, and at no other time.
- R7: testWave starts at 0 after any reset and toggles every 2^(TEST_W-1) counted enables (32 with the defaults, giving 512 Hz), whatever calMag and calSign are.
- R8: The cycle after divReset is sampled high, secTick, minuteMark and testWave are 0. The next second is counted in full from that point, and it is second 0 of minute 0 of the cycle.
- R9: While stopBit is 1, no counter advances, secTick and minuteMark stay 0 and testWave holds its level. A second interrupted by a stop resumes where it left off.
- R10: Second lengths are counted in enables, not in clock cycles, so a gapped oscEn stretches each second in clock cycles but not in enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscEn | input | 1 | One-cycle enable per oscillator period |
| stopBit | input | 1 | 1 freezes the divider |
| divReset | input | 1 | Synchronous clear of the whole divider chain |
| calMag | input | MAG_W | Calibration magnitude N (0 to 31) |
| calSign | input | 1 | 1 = speed up, 0 = slow down |
| secTick | output | 1 | One-cycle pulse per second |
| minuteMark | output | 1 | One-cycle pulse on the last tick of each minute |
| testWave | output | 1 | Uncorrected 512 Hz square wave |

## Verification
A wrong injection or suppression count changes the length of the affected second. That shows at the very next tick. A wrong minute-in-cycle count or eligibility limit shows only in the minute where the trimmed and untrimmed patterns part, which can be up to a full 64-minute cycle later. For that reason the bench sweeps whole cycles past the wrap. A test-wave counter that sees the correction strobes shows as a wrong toggle interval within 32 enables of the trimmed second. A missed clear or stop shows at the first tick after the event.

// File: rtl/calDivPkg.sv
package calDivPkg;
  typedef struct packed {
    logic step;
    logic clear;
    logic inject;
    logic suppress;
  } calStrobe_t;
endpackage

// File: rtl/calDivCtrl.sv
module calDivCtrl
  import calDivPkg::*;
#(
  parameter int STAGE_A_W   = 8,
  parameter int SEC_PER_MIN = 60,
  parameter int MAG_W       = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscEn,
  input  logic             stopBit,
  input  logic             divReset,
  input  logic [MAG_W-1:0] calMag,
  input  logic             calSign,
  input  logic             secDone,
  output calStrobe_t       strobe,
  output logic             minuteMark
);
  localparam int CYC_W    = MAG_W + 1;
  localparam int ELIGIBLE = (1 << CYC_W) - 2;
  localparam int SEC_W    = (SEC_PER_MIN > 2) ? $clog2(SEC_PER_MIN) : 1;
  localparam int CORR_W   = STAGE_A_W + 1;
  localparam int INJ_CNT  = 1 << STAGE_A_W;
  localparam int SUP_CNT  = 1 << (STAGE_A_W - 1);

  logic [SEC_W-1:0]  secIdx;
  logic [CYC_W-1:0]  minIdx;
  logic [CORR_W-1:0] corrCnt;
  logic [CYC_W-1:0]  adjLimit;
  logic              adjSecond;
  logic              step;

  assign step      = oscEn & ~stopBit;
  assign adjLimit  = {calMag, 1'b0};
  assign adjSecond = (secIdx == '0) && (minIdx < adjLimit) &&
                     (minIdx < CYC_W'(ELIGIBLE));

  always_comb begin
    strobe.step     = step;
    strobe.clear    = divReset;
    strobe.inject   = adjSecond & calSign & (corrCnt < CORR_W'(INJ_CNT));
    strobe.suppress = adjSecond & ~calSign & (corrCnt < CORR_W'(SUP_CNT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secIdx     <= '0;
      minIdx     <= '0;
      corrCnt    <= '0;
      minuteMark <= 1'b0;
    end else if (divReset) begin
      secIdx     <= '0;
      minIdx     <= '0;
      corrCnt    <= '0;
      minuteMark <= 1'b0;
    end else begin
      minuteMark <= 1'b0;
      if (step) begin
        if (secDone) begin
          corrCnt <= '0;
          if (secIdx == SEC_W'(SEC_PER_MIN - 1)) begin
            secIdx     <= '0;
            minIdx     <= minIdx + 1'b1;
            minuteMark <= 1'b1;
          end else begin
            secIdx <= secIdx + 1'b1;
          end
        end else if (strobe.inject || strobe.suppress) begin
          corrCnt <= corrCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/calDivPath.sv
module calDivPath
  import calDivPkg::*;
#(
  parameter int STAGE_A_W = 8,
  parameter int STAGE_B_W = 7,
  parameter int TEST_W    = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strobe,
  output logic       secDone,
  output logic       secTick,
  output logic       testWave
);
  localparam int SUM_W = STAGE_A_W + 1;

  logic [STAGE_A_W-1:0] stageA;
  logic [STAGE_B_W-1:0] stageB;
  logic [TEST_W-1:0]    testCnt;
  logic [SUM_W-1:0]     incA;
  logic [SUM_W-1:0]     sumA;
  logic                 carryA;

  always_comb begin
    if (strobe.suppress)    incA = '0;
    else if (strobe.inject) incA = SUM_W'(2);
    else                    incA = SUM_W'(1);
  end

  assign sumA     = {1'b0, stageA} + incA;
  assign carryA   = strobe.step & sumA[STAGE_A_W];
  assign secDone  = carryA & (&stageB);
  assign testWave = testCnt[TEST_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA  <= '0;
      stageB  <= '0;
      testCnt <= '0;
      secTick <= 1'b0;
    end else if (strobe.clear) begin
      stageA  <= '0;
      stageB  <= '0;
      testCnt <= '0;
      secTick <= 1'b0;
    end else begin
      secTick <= secDone;
      if (strobe.step) begin
        stageA  <= sumA[STAGE_A_W-1:0];
        testCnt <= testCnt + 1'b1;
        if (carryA) stageB <= stageB + 1'b1;
      end
    end
  end
endmodule

// File: rtl/calClockDivider.sv
module calClockDivider
  import calDivPkg::*;
#(
  parameter int STAGE_A_W   = 8,
  parameter int STAGE_B_W   = 7,
  parameter int SEC_PER_MIN = 60,
  parameter int TEST_W      = 6,
  parameter int MAG_W       = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscEn,
  input  logic             stopBit,
  input  logic             divReset,
  input  logic [MAG_W-1:0] calMag,
  input  logic             calSign,
  output logic             secTick,
  output logic             minuteMark,
  output logic             testWave
);
  calStrobe_t strobe;
  logic       secDone;

  calDivCtrl #(
    .STAGE_A_W(STAGE_A_W), .SEC_PER_MIN(SEC_PER_MIN), .MAG_W(MAG_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .stopBit(stopBit),
    .divReset(divReset), .calMag(calMag), .calSign(calSign),
    .secDone(secDone), .strobe(strobe), .minuteMark(minuteMark)
  );

  calDivPath #(
    .STAGE_A_W(STAGE_A_W), .STAGE_B_W(STAGE_B_W), .TEST_W(TEST_W)
  ) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .secDone(secDone), .secTick(secTick), .testWave(testWave)
  );
endmodule

// File: rtl/calClockDividerChk.sv
module calClockDividerChk (
  input logic clk,
  input logic rstN,
  input logic oscEn,
  input logic stopBit,
  input logic divReset,
  input logic secTick,
  input logic minuteMark,
  input logic testWave
);
  AST_MINUTE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    minuteMark |-> secTick); // R6

  AST_TICK_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> $past(oscEn && !stopBit && !divReset)); // R9

  AST_CLEAR_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    divReset |=> (!secTick && !minuteMark && !testWave)); // R8

  AST_WAVE_HOLDS_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (stopBit && !divReset) |=> $stable(testWave)); // R9

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick); // R2
endmodule

bind calClockDivider calClockDividerChk i_chk (
  .clk(clk), .rstN(rstN), .oscEn(oscEn), .stopBit(stopBit),
  .divReset(divReset), .secTick(secTick), .minuteMark(minuteMark),
  .testWave(testWave)
);

// File: tb/test_calClockDivider.sv
module test_calClockDivider;
  localparam int CLK_PERIOD = 10;
  localparam int A_W        = 4;
  localparam int B_W        = 2;
  localparam int SPM        = 4;
  localparam int TW         = 6;
  localparam int BASE       = 1 << (A_W + B_W);
  localparam int SHORTEN    = 1 << A_W;
  localparam int LENGTHEN   = 1 << (A_W - 1);
  localparam int WAVE_HALF  = 1 << (TW - 1);
  localparam int LIMIT      = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscEn = 1'b0;
  logic stopBit = 1'b0;
  logic divReset = 1'b0;
  logic calSign = 1'b0;
  logic [4:0] calMag = '0;
  logic gapMode = 1'b0;
  logic secTick, minuteMark, testWave;

  int checks = 0, fails = 0, tickCount = 0, cycles = 0;
  int sinceTick = 0, waveCnt = 0, modelSec = 0, modelMin = 0;
  bit prevStep = 0, prevClear = 1, prevStopped = 0, lastWave = 0, afterClear = 0;

  calClockDivider #(
    .STAGE_A_W(A_W), .STAGE_B_W(B_W), .SEC_PER_MIN(SPM), .TEST_W(TW), .MAG_W(5)
  ) i_calClockDivider (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .stopBit(stopBit),
    .divReset(divReset), .calMag(calMag), .calSign(calSign),
    .secTick(secTick), .minuteMark(minuteMark), .testWave(testWave)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLen(int m, int s, output string tag);
    bit adj = (s == 0) && (m < 2 * int'(calMag)) && (m < 62);
    if (afterClear)        tag = "R8";
    else if (gapMode)      tag = "R10";
    else if (adj)          tag = calSign ? "R3" : "R4";
    else if (calMag != 0)  tag = "R5";
    else                   tag = "R2";
    if (!adj) return BASE;
    return calSign ? BASE - SHORTEN : BASE + LENGTHEN;
  endfunction

  always @(negedge clk) begin
    string tag;
    int exp;
    cycles++;
    if (prevClear) begin
      sinceTick = 0; waveCnt = 0; modelSec = 0; modelMin = 0; afterClear = 1;
    end else if (prevStep) begin
      sinceTick++; waveCnt++;
    end
    if (secTick === 1'b1) begin
      check(prevStep && !prevClear, "R9 tick without event", 1, 0);
      exp = expLen(modelMin, modelSec, tag);
      check(sinceTick == exp, tag, sinceTick, exp);
      check(minuteMark == (modelSec == SPM - 1), "R6", int'(minuteMark),
            int'(modelSec == SPM - 1));
      modelSec++;
      if (modelSec == SPM) begin
        modelSec = 0;
        modelMin = (modelMin + 1) % 64;
      end
      sinceTick = 0; afterClear = 0; tickCount++;
    end else if (minuteMark === 1'b1) begin
      check(0, "R6 mark without tick", 1, 0);
    end
    if (prevStopped && !prevClear)
      check(testWave == lastWave, "R9 wave held", int'(testWave), int'(lastWave));
    if (testWave !== lastWave && testWave !== 1'bx) begin
      if (!prevClear) check(waveCnt == WAVE_HALF, "R7", waveCnt, WAVE_HALF);
      waveCnt = 0;
    end
    lastWave    = (testWave === 1'b1);
    prevStep    = rstN && oscEn && !stopBit && !divReset;
    prevClear   = !rstN || divReset;
    prevStopped = rstN && stopBit && !divReset;
    if (cycles > LIMIT) begin
      check(0, "watchdog", cycles, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      oscEn = gapMode ? ~oscEn : 1'b1;
    end
  end

  task automatic waitTicks(int n);
    int target = tickCount + n;
    while (tickCount < target) @(negedge clk);
  endtask

  task automatic setup(int mag, bit sign, bit gap);
    @(posedge clk); #1;
    calMag = 5'(mag); calSign = sign; gapMode = gap; divReset = 1'b1;
    @(posedge clk); #1;
    divReset = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(secTick == 1'b0, "R1 secTick", int'(secTick), 0);
    check(minuteMark == 1'b0, "R1 minuteMark", int'(minuteMark), 0);
    check(testWave == 1'b0, "R1 testWave", int'(testWave), 0);
    @(posedge clk); #1; rstN = 1'b1;

    setup(0, 1'b0, 1'b0);  waitTicks(70);   // R2 nominal seconds
    setup(1, 1'b1, 1'b0);  waitTicks(260);  // R3 and R5 across the 64-minute wrap
    setup(3, 1'b0, 1'b0);  waitTicks(40);   // R4
    setup(31, 1'b1, 1'b0); waitTicks(260);  // R3, R5 minutes 62 and 63
    setup(31, 1'b0, 1'b0); waitTicks(260);  // R4, R5
    setup(5, 1'b1, 1'b1);  waitTicks(50);   // R10 gapped enable
    setup(2, 1'b0, 1'b0);  waitTicks(6);    // R8 mid-second clear
    repeat (20) @(posedge clk);
    #1 divReset = 1'b1;
    @(posedge clk); #1 divReset = 1'b0;
    @(negedge clk);
    check(secTick == 1'b0 && testWave == 1'b0, "R8 cleared outputs",
          int'({secTick, testWave}), 0);
    waitTicks(12);
    repeat (10) @(posedge clk);              // R9 stop in mid-second
    #1 stopBit = 1'b1;
    repeat (300) @(posedge clk);
    #1 stopBit = 1'b0;
    waitTicks(12);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule